// File: doc/BRIEF.md
# Oldest-First Result Bus Arbiter

This block shares one result broadcast bus among the functional units of an out-of-order core. There are three integer units and one floating-point unit. A unit that has finished executing an instruction raises its request line. With the request it presents the instruction's sequence number, the tag of the reservation station that produced it, and its destination register. In that same cycle the arbiter picks the oldest request in program order and returns a one-hot grant. The grant frees the winning unit and its station entry.

In the next cycle the winner's tag and destination register appear on the bus with the valid bit high, for exactly one cycle. Waiting station entries can match the tag in that cycle. A unit that loses keeps its finished result, stays in execute and keeps requesting until it wins. Units that produce nothing to broadcast, such as stores and branches, never raise a request.

Sequence numbers are one bit wider than the in-flight window needs. Age is therefore judged from the sign of their wrapped difference, which stays correct across counter wraparound.

Top module: `rbus_arbiter`

## Requirements
- R1: The grant vector is one-hot or all-zero in every cycle.
- R2: A grant bit is set only for a unit whose request is high. Whenever any request is high, exactly one grant is given in that same cycle.
- R3: The grant goes to the oldest requester. Sequence a is older than b when bit 4 of (a - b) mod 32 is set. Sequence numbers are 5 bits wide, and unit i's sequence sits in req_seq[5i+4:5i].
- R4: When two requesters present equal sequence numbers, the lower unit index wins.
- R5: The clock edge after a grant drives bus_valid high for one cycle. bus_tag and bus_dst then carry the winner's tag (req_tag[4i+3:4i]) and destination (req_dst[5i+4:5i]).
- R6: In a cycle after a clock edge with no grant, bus_valid is low and both bus_tag and bus_dst are zero.
- R7: A requester that loses keeps its request up. It is granted in a later cycle once no older requester remains, and its own tag is then broadcast.
- R8: While rst is high, grant is all-zero. After a reset edge, bus_valid, bus_tag and bus_dst are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Completion request, one bit per unit |
| req_seq | input | 20 | Program-order sequence number per unit, 5 bits each |
| req_tag | input | 16 | Producing station tag per unit, 4 bits each |
| req_dst | input | 20 | Destination register per unit, 5 bits each |
| grant | output | 4 | One-hot grant; releases the winner's unit and station entry |
| bus_valid | output | 1 | Broadcast valid |
| bus_tag | output | 4 | Broadcast station tag, zero when idle |
| bus_dst | output | 5 | Broadcast destination register, zero when idle |

## Verification
Two things can happen in the same cycle: a unit can be granted while the bus is still broadcasting the previous winner. Two requesters are raised together so that one wins and the other stalls. In the next cycle the bench reads the first winner's tag on the bus and, at the same time, the grant to the stalled unit. A cycle later it reads the stalled unit's tag on the bus. Wraparound is covered by vectors whose oldest sequence number is numerically the largest, and ties by vectors with equal numbers.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
    localparam int NUM_UNITS    = 4;
    localparam int MAX_INFLIGHT = 16;
    localparam int SEQ_W        = $clog2(MAX_INFLIGHT) + 1;
    localparam int TAG_W        = 4;
    localparam int REG_W        = 5;
    localparam int UNIT_IDX_W   = $clog2(NUM_UNITS);

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
        reg_t dst;
    } bcast_t;

    // a is older than b when the wrapped difference is negative
    function automatic logic seq_older(input seq_t a, input seq_t b);
        seq_t diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    // a beats b: strictly older, or same age and lower index
    function automatic logic seq_beats(input seq_t a, input int ia,
                                       input seq_t b, input int ib);
        if (a == b) return (ia < ib);
        return seq_older(a, b);
    endfunction
endpackage

// File: rtl/rbus_oldest_pick.sv
module rbus_oldest_pick
    import rbus_pkg::*;
#(
    parameter int N = NUM_UNITS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [N-1:0] req,
    input  seq_t       seq [N],
    output logic [N-1:0] win
);
    // Each unit wins if it beats every other active requester
    for (genvar i = 0; i < N; i++) begin : g_cand
        always_comb begin
            win[i] = req[i] & ~rst;
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && !seq_beats(seq[i], i, seq[j], j))
                    win[i] = 1'b0;
            end
        end

        for (genvar j = 0; j < N; j++) begin : g_pair
            if (j != i) begin : g_chk
                // R3: no active requester older than the winner
                a_r3_winner_oldest: assert property (@(posedge clk) disable iff (rst)
                    (win[i] && req[j]) |-> !seq_older(seq[j], seq[i]));
                // R4: equal age resolves toward lower index
                a_r4_tie_low_index: assert property (@(posedge clk) disable iff (rst)
                    (win[i] && req[j] && seq[j] == seq[i]) |-> (i < j));
            end
        end
    end
endmodule

// File: rtl/rbus_bcast_reg.sv
module rbus_bcast_reg
    import rbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  tag_t tag_in,
    input  reg_t dst_in,
    output bcast_t bus
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus <= '0;
        end else if (fire) begin
            bus.valid <= 1'b1;
            bus.tag   <= tag_in;
            bus.dst   <= dst_in;
        end else begin
            bus <= '0;
        end
    end

    // R6: idle bus carries zero tag and destination
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus.valid |-> (bus.tag == '0 && bus.dst == '0));
endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter
    import rbus_pkg::*;
#(
    parameter int N = NUM_UNITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic [N*SEQ_W-1:0]   req_seq,
    input  logic [N*TAG_W-1:0]   req_tag,
    input  logic [N*REG_W-1:0]   req_dst,
    output logic [N-1:0]         grant,
    output logic                 bus_valid,
    output logic [TAG_W-1:0]     bus_tag,
    output logic [REG_W-1:0]     bus_dst
);
    seq_t   seq_a [N];
    tag_t   tag_a [N];
    reg_t   dst_a [N];
    tag_t   sel_tag;
    reg_t   sel_dst;
    logic   fire;
    bcast_t bus;

    for (genvar i = 0; i < N; i++) begin : g_unpack
        assign seq_a[i] = req_seq[i*SEQ_W +: SEQ_W];
        assign tag_a[i] = req_tag[i*TAG_W +: TAG_W];
        assign dst_a[i] = req_dst[i*REG_W +: REG_W];
    end

    rbus_oldest_pick #(.N(N)) u_pick (
        .clk (clk),
        .rst (rst),
        .req (req),
        .seq (seq_a),
        .win (grant)
    );

    // One-hot AND-OR select of the winner's fields
    always_comb begin
        sel_tag = '0;
        sel_dst = '0;
        for (int i = 0; i < N; i++) begin
            sel_tag |= tag_a[i] & {TAG_W{grant[i]}};
            sel_dst |= dst_a[i] & {REG_W{grant[i]}};
        end
    end

    assign fire = |grant;

    rbus_bcast_reg u_bcast (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .tag_in (sel_tag),
        .dst_in (sel_dst),
        .bus    (bus)
    );

    assign bus_valid = bus.valid;
    assign bus_tag   = bus.tag;
    assign bus_dst   = bus.dst;

    // R1
    a_r1_grant_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R2
    a_r2_grant_only_req: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);
    a_r2_no_idle_bus: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> $countones(grant) == 1);
    // R5
    a_r5_bus_follows: assert property (@(posedge clk) disable iff (rst)
        fire |=> (bus_valid && bus_tag == $past(sel_tag) && bus_dst == $past(sel_dst)));
    // R6
    a_r6_no_grant_quiet: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !bus_valid);
    // R8
    a_r8_reset_no_grant: assert property (@(posedge clk)
        rst |-> grant == '0);
endmodule

// File: tb/rbus_arbiter_bench.sv
`timescale 1ns/1ps
module rbus_arbiter_bench;
    localparam int N  = 4;
    localparam int SW = 5;
    localparam int TW = 4;
    localparam int RW = 5;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]    req = '0;
    logic [N*SW-1:0] req_seq = '0;
    logic [N*TW-1:0] req_tag = '0;
    logic [N*RW-1:0] req_dst = '0;
    logic [N-1:0]    grant;
    logic            bus_valid;
    logic [TW-1:0]   bus_tag;
    logic [RW-1:0]   bus_dst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rbus_arbiter u_rbus_arbiter (
        .clk(clk), .rst(rst), .req(req), .req_seq(req_seq),
        .req_tag(req_tag), .req_dst(req_dst), .grant(grant),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_dst(bus_dst)
    );

    // Vector table: requests, sequences {u3,u2,u1,u0}, expected grant
    localparam logic [N-1:0] V_REQ [NV] = '{
        4'b0001, 4'b1111, 4'b1010, 4'b0011, 4'b1100, 4'b0110, 4'b0000, 4'b1111};
    localparam logic [N*SW-1:0] V_SEQ [NV] = '{
        {5'd0,  5'd0,  5'd0,  5'd3},
        {5'd7,  5'd2,  5'd9,  5'd4},
        {5'd1,  5'd0,  5'd6,  5'd0},
        {5'd0,  5'd0,  5'd1,  5'd30},
        {5'd31, 5'd3,  5'd0,  5'd0},
        {5'd0,  5'd5,  5'd5,  5'd0},
        {5'd0,  5'd0,  5'd0,  5'd0},
        {5'd20, 5'd22, 5'd19, 5'd21}};
    localparam logic [N-1:0] V_EXP [NV] = '{
        4'b0001, 4'b0100, 4'b1000, 4'b0001, 4'b1000, 4'b0010, 4'b0000, 4'b0010};
    localparam string V_REQID [NV] = '{
        "R2", "R3", "R3", "R3", "R3", "R4", "R6", "R1"};

    function automatic logic [TW-1:0] tag_of(int v, int u);
        return TW'((v * 3 + u + 1) % 16);
    endfunction
    function automatic logic [RW-1:0] dst_of(int v, int u);
        return RW'((v * 5 + u * 7 + 2) % 32);
    endfunction

    task automatic check(string rid, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rid, what, act, exp);
        end
    endtask

    task automatic load(int v);
        for (int u = 0; u < N; u++) begin
            req_tag[u*TW +: TW] = tag_of(v, u);
            req_dst[u*RW +: RW] = dst_of(v, u);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int w;
        // R8: reset holds grant low and clears the bus
        @(negedge clk);
        req = 4'b1111;
        req_seq = {5'd4, 5'd3, 5'd2, 5'd1};
        load(9);
        #1 check("R8", "grant in reset", 32'(grant), 32'h0);
        @(posedge clk); #1;
        check("R8", "bus_valid after reset", 32'(bus_valid), 32'h0);
        check("R8", "bus_tag after reset", 32'(bus_tag), 32'h0);
        @(negedge clk);
        req = '0;
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            req = V_REQ[v];
            req_seq = V_SEQ[v];
            load(v);
            #1 check(V_REQID[v], $sformatf("grant vec %0d", v), 32'(grant), 32'(V_EXP[v]));
            @(posedge clk); #1;
            if (V_EXP[v] == '0) begin
                check("R6", $sformatf("idle valid vec %0d", v), 32'(bus_valid), 32'h0);
                check("R6", $sformatf("idle tag/dst vec %0d", v), {bus_tag, bus_dst}, 32'h0);
            end else begin
                w = 0;
                for (int u = 0; u < N; u++) if (V_EXP[v][u]) w = u;
                check("R5", $sformatf("bus valid vec %0d", v), 32'(bus_valid), 32'h1);
                check("R5", $sformatf("bus tag vec %0d", v), 32'(bus_tag), 32'(tag_of(v, w)));
                check("R5", $sformatf("bus dst vec %0d", v), 32'(bus_dst), 32'(dst_of(v, w)));
            end
        end

        // R7: loser stalls, then wins while the first winner broadcasts
        @(negedge clk);
        req = 4'b0101;
        req_seq = {5'd0, 5'd3, 5'd0, 5'd5};
        load(11);
        #1 check("R7", "first winner is older u2", 32'(grant), 32'h4);
        @(negedge clk);
        check("R7", "bus carries u2 tag", 32'(bus_tag), 32'(tag_of(11, 2)));
        req = 4'b0001;
        #1 check("R7", "stalled u0 now granted", 32'(grant), 32'h1);
        @(negedge clk);
        check("R7", "bus carries u0 tag", 32'(bus_tag), 32'(tag_of(11, 0)));
        check("R7", "bus valid for u0", 32'(bus_valid), 32'h1);
        req = '0;
        @(negedge clk);
        check("R5", "single-cycle broadcast then idle", 32'(bus_valid), 32'h0);
        check("R6", "tag cleared when idle", 32'(bus_tag), 32'h0);

        // R2: only requester granted even if others carry older seq
        req = 4'b1000;
        req_seq = {5'd9, 5'd1, 5'd1, 5'd1};
        #1 check("R2", "lone requester u3", 32'(grant), 32'h8);
        @(negedge clk);
        req = '0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule